// File: doc/BRIEF.md
# Camera Pixel Packer

This block sits right behind a camera sensor's 8-bit parallel port. The sensor sends each RGB444 pixel as two bytes while its line-valid signal (`href`) is high. The block pairs those two bytes and keeps three red bits from the first byte. From the second byte it keeps three green bits and two blue bits. It then presents one RGB332 pixel together with a frame-buffer write strobe and a linear write address.

Everything runs on the sensor's pixel clock. The block keeps an x/y position that advances by one for each finished pixel. A falling edge of `href` closes a row, and a rising edge of `vsync` starts a new frame. The stored image is 176 by 144 pixels, kept row by row. Pixels that fall outside that window produce no write strobe, so an oversized sensor frame can never write past the end of the buffer.

Top module: `cam_pixel_packer`

## Requirements
- R1: A byte is taken only on a `pclk` edge where `href` is high. Data presented while `href` is low changes neither `wr_en`, `x_pos` nor `y_pos`.
- R2: Bytes taken within one row alternate between first byte and second byte of a pixel. The first byte taken after `href` rises is always a first byte.
- R3: `pixel` bits 7:5 (red) equal bits 3:1 of the pixel's first byte.
- R4: `pixel` bits 4:2 (green) equal bits 7:5 of the pixel's second byte, and `pixel` bits 1:0 (blue) equal bits 3:2 of that byte.
- R5: `wr_en` is high for exactly the one cycle after the edge that takes a second byte, and is low after a first byte. On that same edge `x_pos` increments by one.
- R6: On an edge where `href` is low after being high, `x_pos` becomes 0 and `y_pos` increments by one (saturating at its all-ones value).
- R7: On an edge where `vsync` is high after being low, `x_pos` and `y_pos` both become 0. This takes priority over a row end in the same cycle.
- R8: While `wr_en` is high, `wr_addr` equals y*176+x, where x and y are the coordinates of the pixel just completed. It is 15 bits wide.
- R9: `wr_en` stays low for a completed pixel whose x is 176 or more, or whose y is 144 or more.
- R10: After an active-low reset, `pixel`, `x_pos`, `y_pos`, `wr_addr` and `wr_en` are all zero.
- R11: If a row ends after an odd number of bytes, the dangling byte is dropped. The next row still pairs its bytes from its own first byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Sensor pixel clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cam_data | input | 8 | Sensor data byte |
| href | input | 1 | Line-valid from the sensor; high while row bytes are sent |
| vsync | input | 1 | Frame sync from the sensor; rising edge starts a frame |
| pixel | output | 8 | Packed RGB332 pixel, red in 7:5, green in 4:2, blue in 1:0 |
| x_pos | output | 8 | Column the next completed pixel will take |
| y_pos | output | 8 | Current row |
| wr_addr | output | 15 | Linear frame-buffer address of the pixel just completed |
| wr_en | output | 1 | One-cycle frame-buffer write strobe |

## Verification
Single pixels use byte pairs chosen so that each colour field is all ones in turn while the others are zero. A wrong bit pick or a swapped field then shows up in exactly one position. Runs of pixels across row ends and frame starts show whether the address steps by one within a row and jumps by 176 per row, and whether a simultaneous frame start outranks a row end. A row cut after an odd byte count separates a design that re-aligns the byte phase from one that carries it across rows. Rows pushed past column 175 and frames pushed past row 143 show where the write strobe stops.

// File: rtl/cpk_pkg.sv
// Package: shared pixel type and packing function for the camera pixel packer.
// Assumes the sensor sends RGB444 with red in bits 3:0 of the first byte and
// green/blue in bits 7:4 / 3:0 of the second byte.
package cpk_pkg;

    typedef struct packed {
        logic [2:0] red;
        logic [2:0] green;
        logic [1:0] blue;
    } rgb332_t;

    // Build an RGB332 pixel from the held red bits and the second byte.
    function automatic rgb332_t pack_rgb332(input logic [2:0] red_bits,
                                            input logic [7:0] second_byte);
        rgb332_t p;
        p.red   = red_bits;
        p.green = second_byte[7:5];
        p.blue  = second_byte[3:2];
        return p;
    endfunction

endpackage

// File: rtl/cpk_sync_edges.sv
// Sync edge finder: keeps the previous href and vsync levels on the pixel clock
// and flags a frame start (vsync rising) and a row end (href falling).
// Assumes href and vsync are already synchronous to pclk.
module cpk_sync_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic href,
    input  logic vsync,
    output logic href_prev,
    output logic vsync_prev,
    output logic frame_start,
    output logic row_end
);

    // Hold last-cycle levels of both sync inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            href_prev  <= 1'b0;
            vsync_prev <= 1'b0;
        end else begin
            href_prev  <= href;
            vsync_prev <= vsync;
        end
    end

    // Edge decode; a frame start masks a coincident row end.
    always_comb begin
        frame_start = vsync && !vsync_prev;
        row_end     = !href && href_prev && !frame_start;
    end

endmodule

// File: rtl/cpk_byte_pair.sv
// Byte pairer: tracks the byte phase within a row, holds the red bits of the
// first byte and emits the packed pixel when the second byte arrives.
// Assumes bytes are valid on every pclk edge with href high.
module cpk_byte_pair
    import cpk_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              href,
    input  logic              frame_start,
    input  logic [DATA_W-1:0] data,
    output logic              pair_done,
    output rgb332_t           pixel_q
);

    logic       phase_q;
    logic [2:0] red_q;
    logic       take;

    // A byte counts only inside a line and not on a frame-start edge.
    always_comb begin
        take      = href && !frame_start;
        pair_done = take && phase_q;
    end

    // Byte phase: cleared outside a line, toggled on every taken byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= 1'b0;
        else if (!take)
            phase_q <= 1'b0;
        else
            phase_q <= !phase_q;
    end

    // Red hold and pixel register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            red_q   <= '0;
            pixel_q <= '0;
        end else if (take) begin
            if (!phase_q)
                red_q <= data[3:1];
            else
                pixel_q <= pack_rgb332(red_q, data[7:0]);
        end
    end

endmodule

// File: rtl/cpk_coord_gen.sv
// Coordinate generator: keeps x/y, forms the linear address of each completed
// pixel and raises a one-cycle write strobe for pixels inside the window.
// Assumes frame_start, row_end and pair_done are mutually exclusive per cycle.
module cpk_coord_gen #(
    parameter int FRAME_W = 176,
    parameter int FRAME_H = 144,
    parameter int COORD_W = 8,
    parameter int ADDR_W  = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               row_end,
    input  logic               pair_done,
    output logic [COORD_W-1:0] x_q,
    output logic [COORD_W-1:0] y_q,
    output logic [ADDR_W-1:0]  addr_q,
    output logic               wr_q
);

    localparam logic [COORD_W-1:0] COORD_MAX = '1;

    logic        in_win;
    logic [31:0] lin;

    // Window test and row-major address of the current x/y.
    always_comb begin
        in_win = (32'(x_q) < 32'(FRAME_W)) && (32'(y_q) < 32'(FRAME_H));
        lin    = 32'(y_q) * 32'(FRAME_W) + 32'(x_q);
    end

    // Coordinate update in priority: frame start, row end, pixel done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= '0;
            y_q <= '0;
        end else if (frame_start) begin
            x_q <= '0;
            y_q <= '0;
        end else if (row_end) begin
            x_q <= '0;
            if (y_q != COORD_MAX)
                y_q <= y_q + 1'b1;
        end else if (pair_done && x_q != COORD_MAX) begin
            x_q <= x_q + 1'b1;
        end
    end

    // Write strobe and address of the pixel just finished.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q   <= 1'b0;
            addr_q <= '0;
        end else begin
            wr_q <= pair_done && in_win;
            if (pair_done)
                addr_q <= lin[ADDR_W-1:0];
        end
    end

endmodule

// File: rtl/cam_pixel_packer.sv
// Camera pixel packer top: turns two-byte RGB444 sensor pixels into RGB332
// frame-buffer writes with row-major addresses.
// Assumes cam_data, href and vsync change synchronously to pclk.
module cam_pixel_packer #(
    parameter int FRAME_W = 176,
    parameter int FRAME_H = 144,
    parameter int COORD_W = 8,
    parameter int ADDR_W  = 15
) (
    input  logic               pclk,
    input  logic               rst_n,
    input  logic [7:0]         cam_data,
    input  logic               href,
    input  logic               vsync,
    output logic [7:0]         pixel,
    output logic [COORD_W-1:0] x_pos,
    output logic [COORD_W-1:0] y_pos,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic               wr_en
);

    import cpk_pkg::*;

    logic    href_prev;
    logic    vsync_prev;
    logic    frame_start;
    logic    row_end;
    logic    pair_done;
    rgb332_t pix_s;

    cpk_sync_edges u_edges (
        .clk         (pclk),
        .rst_n       (rst_n),
        .href        (href),
        .vsync       (vsync),
        .href_prev   (href_prev),
        .vsync_prev  (vsync_prev),
        .frame_start (frame_start),
        .row_end     (row_end)
    );

    cpk_byte_pair #(.DATA_W(8)) u_pair (
        .clk         (pclk),
        .rst_n       (rst_n),
        .href        (href),
        .frame_start (frame_start),
        .data        (cam_data),
        .pair_done   (pair_done),
        .pixel_q     (pix_s)
    );

    cpk_coord_gen #(
        .FRAME_W (FRAME_W),
        .FRAME_H (FRAME_H),
        .COORD_W (COORD_W),
        .ADDR_W  (ADDR_W)
    ) u_coord (
        .clk         (pclk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .row_end     (row_end),
        .pair_done   (pair_done),
        .x_q         (x_pos),
        .y_q         (y_pos),
        .addr_q      (wr_addr),
        .wr_q        (wr_en)
    );

    // Present the packed pixel as a plain byte.
    always_comb pixel = pix_s;

endmodule

// File: rtl/cpk_checker.sv
// Checker for cam_pixel_packer: timing properties of strobe, coordinates
// and address. Attached to the top with the bind below.
module cpk_checker #(
    parameter int FRAME_W = 176,
    parameter int FRAME_H = 144,
    parameter int COORD_W = 8,
    parameter int ADDR_W  = 15
) (
    input logic               clk,
    input logic               rst_n,
    input logic               href,
    input logic               vsync,
    input logic               href_prev,
    input logic               vsync_prev,
    input logic [COORD_W-1:0] x_pos,
    input logic [COORD_W-1:0] y_pos,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic               wr_en
);

    localparam logic [COORD_W-1:0] C_MAX = '1;

    // R1: no strobe unless a byte was taken on the previous edge.
    p_strobe_needs_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(href));

    // R5: strobe lasts one cycle and x has stepped by one.
    p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
    p_x_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (x_pos == COORD_W'($past(x_pos) + 1'b1)));

    // R6: row end clears x and steps y.
    p_row_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!href && href_prev && !(vsync && !vsync_prev) && y_pos != C_MAX)
        |=> (x_pos == '0 && y_pos == COORD_W'($past(y_pos) + 1'b1)));

    // R7: frame start clears both coordinates.
    p_frame_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync && !vsync_prev) |=> (x_pos == '0 && y_pos == '0 && !wr_en));

    // R9: a strobed address always lies inside the frame.
    p_addr_in_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (32'(wr_addr) < FRAME_W * FRAME_H));

endmodule

bind cam_pixel_packer cpk_checker #(
    .FRAME_W (FRAME_W),
    .FRAME_H (FRAME_H),
    .COORD_W (COORD_W),
    .ADDR_W  (ADDR_W)
) u_cpk_checker (
    .clk        (pclk),
    .rst_n      (rst_n),
    .href       (href),
    .vsync      (vsync),
    .href_prev  (href_prev),
    .vsync_prev (vsync_prev),
    .x_pos      (x_pos),
    .y_pos      (y_pos),
    .wr_addr    (wr_addr),
    .wr_en      (wr_en)
);

// File: tb/cam_pixel_packer_test.sv
// Directed bench for cam_pixel_packer: one task per scenario.
module cam_pixel_packer_test;

    logic        pclk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cam_data = '0;
    logic        href = 1'b0;
    logic        vsync = 1'b0;
    logic [7:0]  pixel;
    logic [7:0]  x_pos;
    logic [7:0]  y_pos;
    logic [14:0] wr_addr;
    logic        wr_en;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 pclk = ~pclk;

    cam_pixel_packer uut (
        .pclk     (pclk),
        .rst_n    (rst_n),
        .cam_data (cam_data),
        .href     (href),
        .vsync    (vsync),
        .pixel    (pixel),
        .x_pos    (x_pos),
        .y_pos    (y_pos),
        .wr_addr  (wr_addr),
        .wr_en    (wr_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_pix(input logic [7:0] b0, input logic [7:0] b1);
        return {b0[3:1], b1[7:5], b1[3:2]};
    endfunction

    task automatic tick();
        @(posedge pclk);
        #1;
    endtask

    task automatic send_byte(input logic [7:0] d);
        @(negedge pclk);
        href = 1'b1;
        cam_data = d;
        tick();
    endtask

    task automatic end_row();
        @(negedge pclk);
        href = 1'b0;
        tick();
    endtask

    task automatic start_frame();
        @(negedge pclk);
        href = 1'b0;
        vsync = 1'b1;
        tick();
        @(negedge pclk);
        vsync = 1'b0;
        tick();
    endtask

    // Send a pixel and check strobe, pixel and address.
    task automatic send_pixel(input logic [7:0] b0, input logic [7:0] b1,
                              input int addr, input bit win);
        send_byte(b0);
        chk("R5 wr_en after first byte", int'(wr_en), 0);
        send_byte(b1);
        chk("R5 wr_en after second byte", int'(wr_en), int'(win));
        if (win) begin
            chk("R3/R4 pixel", int'(pixel), int'(exp_pix(b0, b1)));
            chk("R8 address", int'(wr_addr), addr);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        @(negedge pclk);
        rst_n = 1'b1;
        tick();
        chk("R10 pixel", int'(pixel), 0);
        chk("R10 x", int'(x_pos), 0);
        chk("R10 y", int'(y_pos), 0);
        chk("R10 addr", int'(wr_addr), 0);
        chk("R10 wr_en", int'(wr_en), 0);
    endtask

    task automatic t_fields_and_rows();
        start_frame();
        send_pixel(8'h0E, 8'h00, 0, 1);   // red only -> E0
        chk("R3 red field", int'(pixel), 8'hE0);
        send_pixel(8'hF1, 8'hEC, 1, 1);   // green+blue -> 1F
        chk("R4 green/blue field", int'(pixel), 8'h1F);
        send_pixel(8'h0A, 8'hA4, 2, 1);   // mixed -> B5
        chk("R2 pairing pixel", int'(pixel), 8'hB5);
        chk("R5 x after three pixels", int'(x_pos), 3);
        end_row();
        chk("R6 x cleared", int'(x_pos), 0);
        chk("R6 y stepped", int'(y_pos), 1);
        send_pixel(8'h06, 8'h60, 176, 1);
        end_row();
    endtask

    task automatic t_href_low_ignored();
        for (int i = 0; i < 6; i++) begin
            @(negedge pclk);
            href = 1'b0;
            cam_data = 8'(8'hA5 + i);
            tick();
            chk("R1 no strobe with href low", int'(wr_en), 0);
        end
        chk("R1 x unchanged", int'(x_pos), 0);
        chk("R1 y unchanged", int'(y_pos), 2);
    endtask

    task automatic t_odd_row();
        send_byte(8'hFF);      // dangling byte
        end_row();
        chk("R11 y after odd row", int'(y_pos), 3);
        send_pixel(8'h02, 8'h48, 3 * 176, 1);
        chk("R11 realigned pixel", int'(pixel), 8'h2A);
    endtask

    task automatic t_vsync_priority();
        send_pixel(8'h0C, 8'h80, 3 * 176 + 1, 1);
        @(negedge pclk);
        href = 1'b0;
        vsync = 1'b1;
        tick();
        chk("R7 x cleared", int'(x_pos), 0);
        chk("R7 y cleared over row end", int'(y_pos), 0);
        @(negedge pclk);
        vsync = 1'b0;
        tick();
        send_pixel(8'h0E, 8'hFC, 0, 1);
        end_row();
    endtask

    task automatic t_x_window();
        start_frame();
        for (int i = 0; i < 176; i++)
            send_pixel(8'(i), 8'(i * 3), i, 1);
        send_pixel(8'h0E, 8'hFC, 0, 0);
        chk("R9 no strobe past column 175", int'(wr_en), 0);
        end_row();
    endtask

    task automatic t_y_window();
        start_frame();
        for (int r = 0; r < 143; r++) begin
            send_byte(8'h00);
            end_row();
        end
        chk("R6 y reached 143", int'(y_pos), 143);
        send_pixel(8'h08, 8'h24, 143 * 176, 1);
        end_row();
        send_pixel(8'h08, 8'h24, 0, 0);
        chk("R9 no strobe on row 144", int'(wr_en), 0);
        end_row();
    endtask

    initial begin
        t_reset();
        t_fields_and_rows();
        t_href_low_ignored();
        t_odd_row();
        t_vsync_priority();
        t_x_window();
        t_y_window();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge pclk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule